// File: doc/BRIEF.md
# UART Control Register

This block is the control word of a serial port, reached over a plain register bus with one write strobe, one read strobe and 32-bit data. It keeps the transmitter and receiver switch bits and turns each on/off pair into one effective enable. It also keeps the two line-break request bits for the break generator.

Three bits in the word are commands: transmit-path reset, receive-path reset and receiver-timeout restart. Writing a one to a command bit raises a level request towards its datapath. The request stays high until that datapath returns a one-cycle done pulse. The bit then clears itself. The two path resets also send a one-cycle flush pulse to the FIFO of their path. The datapaths themselves lie outside this block.

Top module: `uart_ctl_reg`

## Requirements
- R1: After a synchronous reset the word reads 0x00000128. That is bit 8 (break halt), bit 5 (transmit off) and bit 3 (receive off) set and all others clear. Both enables, all requests and both flush pulses are low, `brk_halt` is high and `brk_go` is low.
- R2: Bits 31:9 always read as zero, and writing ones to them changes neither the read-back value nor any output.
- R3: `tx_enable` is high exactly when bit 4 (transmit on) is 1 and bit 5 (transmit off) is 0. It follows a write on the clock edge that takes the write.
- R4: `rx_enable` is high exactly when bit 2 (receive on) is 1 and bit 3 (receive off) is 0. A set bit 3 keeps the receiver off whatever bit 2 holds.
- R5: Writing 1 to bit 1 raises `tx_rst_req` on the edge that takes the write. Bit 1 reads as 1 while the request is high. The request and bit 1 drop on the edge that samples `tx_rst_done` high.
- R6: Writing 1 to bit 0 raises `rx_rst_req` in the same way. It is held until the edge that samples `rx_rst_done`, then clears along with bit 0.
- R7: Writing 1 to bit 6 raises `rto_restart_req` in the same way. It is held until the edge that samples `rto_done`, then clears along with bit 6.
- R8: The following have no effect on a command: writing 0 to its bit, writing 1 to it while it is pending, a done pulse while it is idle, and a write of 1 that lands in the same cycle as its done pulse. None of these raises a new request or a new flush pulse.
- R9: Starting a transmit-path reset makes `tx_flush` high for exactly one cycle, and starting a receive-path reset does the same for `rx_flush`. Both flush pulses coincide with the first cycle of the request. A timeout restart pulses neither.
- R10: Bit 8 (break halt) takes the written value on every write. Bit 7 (break go) is stored as 1 only if the same write holds bit 8 at 0, and otherwise as 0. `brk_go` and `brk_halt` show the stored bits, so the two are never high together.
- R11: `rd_data` is registered. It shows the word as it stood in the cycle that `rd_en` was high, before any write in that same cycle, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| tx_enable | output | 1 | Effective transmitter enable |
| rx_enable | output | 1 | Effective receiver enable |
| tx_rst_req | output | 1 | Transmit-path reset request (level) |
| rx_rst_req | output | 1 | Receive-path reset request (level) |
| rto_restart_req | output | 1 | Receiver-timeout restart request (level) |
| tx_rst_done | input | 1 | Transmit-path reset complete pulse |
| rx_rst_done | input | 1 | Receive-path reset complete pulse |
| rto_done | input | 1 | Timeout restart complete pulse |
| tx_flush | output | 1 | One-cycle transmit FIFO flush pulse |
| rx_flush | output | 1 | One-cycle receive FIFO flush pulse |
| brk_go | output | 1 | Break start request to the break logic |
| brk_halt | output | 1 | Break stop request to the break logic |

## Verification
A command's completion and a fresh write of 1 to the same command bit can land on one clock edge. To provoke this, the bench leaves each command pending and then raises the done pulse and a write of that bit in the same cycle. It passes only if the request drops and no flush pulse or new request follows. A read and a write are also issued in the same cycle, and the read must return the word as it stood before the write.

// File: rtl/uart_ctl_pkg.sv
`timescale 1ns/1ps
package uart_ctl_pkg;
  localparam int CTL_W   = 32;
  localparam int USED_W  = 9;

  // field positions seen by software
  localparam int P_RXRST = 0;
  localparam int P_TXRST = 1;
  localparam int P_RXON  = 2;
  localparam int P_RXOFF = 3;
  localparam int P_TXON  = 4;
  localparam int P_TXOFF = 5;
  localparam int P_RTO   = 6;
  localparam int P_BRKGO = 7;
  localparam int P_BRKHL = 8;

  // self-clearing command slots
  localparam int N_CMD = 3;
  localparam int CMD_POS   [N_CMD] = '{P_RXRST, P_TXRST, P_RTO};
  localparam bit CMD_FLUSH [N_CMD] = '{1'b1, 1'b1, 1'b0};
  localparam int SLOT_RX  = 0;
  localparam int SLOT_TX  = 1;
  localparam int SLOT_RTO = 2;
endpackage

// File: rtl/uctl_cmd_slot.sv
`timescale 1ns/1ps
// One self-clearing command: a level request held until done, with an
// optional one-cycle flush pulse on start.
module uctl_cmd_slot #(
  parameter bit HAS_FLUSH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic done,
  output logic pending,
  output logic flush
);
  logic start;
  assign start = set_req & ~pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
    end else if (pending) begin
      if (done) pending <= 1'b0;
    end else if (start) begin
      pending <= 1'b1;
    end
  end

  generate
    if (HAS_FLUSH) begin : g_flush
      always_ff @(posedge clk) begin
        if (rst) flush <= 1'b0;
        else     flush <= start;
      end
    end else begin : g_noflush
      assign flush = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/uctl_en_pair.sv
`timescale 1ns/1ps
// On/off bit pair with a registered effective enable; off dominates.
module uctl_en_pair #(
  parameter bit ON_INIT  = 1'b0,
  parameter bit OFF_INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic on_d,
  input  logic off_d,
  output logic on_q,
  output logic off_q,
  output logic en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      on_q  <= ON_INIT;
      off_q <= OFF_INIT;
      en_q  <= ON_INIT & ~OFF_INIT;
    end else if (load) begin
      on_q  <= on_d;
      off_q <= off_d;
      en_q  <= on_d & ~off_d;
    end
  end
endmodule

// File: rtl/uctl_break.sv
`timescale 1ns/1ps
// Break request pair: go is accepted only while the written halt is 0.
module uctl_break (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic go_d,
  input  logic halt_d,
  output logic go_q,
  output logic halt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      go_q   <= 1'b0;
      halt_q <= 1'b1;
    end else if (load) begin
      go_q   <= go_d & ~halt_d;
      halt_q <= halt_d;
    end
  end
endmodule

// File: rtl/uart_ctl_reg.sv
`timescale 1ns/1ps
module uart_ctl_reg
  import uart_ctl_pkg::*;
#(
  parameter int DATA_W = CTL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic              tx_rst_req,
  output logic              rx_rst_req,
  output logic              rto_restart_req,
  input  logic              tx_rst_done,
  input  logic              rx_rst_done,
  input  logic              rto_done,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic              brk_go,
  output logic              brk_halt
);
  localparam int RSVD_W = DATA_W - USED_W;

  logic [N_CMD-1:0] done_vec, pend_vec, flush_vec;
  logic tx_on, tx_off, rx_on, rx_off;
  logic [DATA_W-1:0] image;

  assign done_vec[SLOT_RX]  = rx_rst_done;
  assign done_vec[SLOT_TX]  = tx_rst_done;
  assign done_vec[SLOT_RTO] = rto_done;

  generate
    for (genvar g = 0; g < N_CMD; g++) begin : g_cmd
      uctl_cmd_slot #(.HAS_FLUSH(CMD_FLUSH[g])) u_slot (
        .clk     (clk),
        .rst     (rst),
        .set_req (wr_en & wr_data[CMD_POS[g]]),
        .done    (done_vec[g]),
        .pending (pend_vec[g]),
        .flush   (flush_vec[g])
      );
    end
  endgenerate

  assign rx_rst_req      = pend_vec[SLOT_RX];
  assign tx_rst_req      = pend_vec[SLOT_TX];
  assign rto_restart_req = pend_vec[SLOT_RTO];
  assign rx_flush        = flush_vec[SLOT_RX];
  assign tx_flush        = flush_vec[SLOT_TX];

  uctl_en_pair #(.ON_INIT(1'b0), .OFF_INIT(1'b1)) u_tx_pair (
    .clk(clk), .rst(rst), .load(wr_en),
    .on_d(wr_data[P_TXON]), .off_d(wr_data[P_TXOFF]),
    .on_q(tx_on), .off_q(tx_off), .en_q(tx_enable)
  );

  uctl_en_pair #(.ON_INIT(1'b0), .OFF_INIT(1'b1)) u_rx_pair (
    .clk(clk), .rst(rst), .load(wr_en),
    .on_d(wr_data[P_RXON]), .off_d(wr_data[P_RXOFF]),
    .on_q(rx_on), .off_q(rx_off), .en_q(rx_enable)
  );

  uctl_break u_brk (
    .clk(clk), .rst(rst), .load(wr_en),
    .go_d(wr_data[P_BRKGO]), .halt_d(wr_data[P_BRKHL]),
    .go_q(brk_go), .halt_q(brk_halt)
  );

  always_comb begin
    image = '0;
    for (int g = 0; g < N_CMD; g++) image[CMD_POS[g]] = pend_vec[g];
    image[P_RXON]  = rx_on;
    image[P_RXOFF] = rx_off;
    image[P_TXON]  = tx_on;
    image[P_TXOFF] = tx_off;
    image[P_BRKGO] = brk_go;
    image[P_BRKHL] = brk_halt;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= image;
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data[DATA_W-1 -: RSVD_W], flush_vec[SLOT_RTO]};
endmodule

// File: rtl/uart_ctl_reg_chk.sv
`timescale 1ns/1ps
module uart_ctl_reg_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              tx_enable,
  input logic              rx_enable,
  input logic              tx_rst_req,
  input logic              rx_rst_req,
  input logic              rto_restart_req,
  input logic              tx_rst_done,
  input logic              rx_rst_done,
  input logic              rto_done,
  input logic              tx_flush,
  input logic              rx_flush,
  input logic              brk_go,
  input logic              brk_halt
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data[DATA_W-1:9] == '0);

  // R3
  tx_en_follow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> tx_enable == ($past(wr_data[4]) & ~$past(wr_data[5])));

  // R4
  rx_off_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[3]) |=> !rx_enable);

  // R5
  tx_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_rst_req && !tx_rst_done) |=> tx_rst_req);

  // R5
  tx_req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_rst_req && tx_rst_done) |=> !tx_rst_req);

  // R6
  rx_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_rst_req && !rx_rst_done) |=> rx_rst_req);

  // R7
  rto_req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rto_restart_req && rto_done) |=> !rto_restart_req);

  // R9
  tx_flush_edge_chk: assert property (@(posedge clk) disable iff (rst)
    tx_flush |-> $rose(tx_rst_req));

  // R9
  rx_flush_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rx_flush |-> $rose(rx_rst_req));

  // R10
  brk_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(brk_go && brk_halt));
endmodule

bind uart_ctl_reg uart_ctl_reg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/uart_ctl_reg_bench.sv
`timescale 1ns/1ps
module uart_ctl_reg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tx_enable, rx_enable, tx_rst_req, rx_rst_req, rto_restart_req;
  logic        tx_flush, rx_flush, brk_go, brk_halt;
  logic [2:0]  dn = '0;   // [0] rx, [1] tx, [2] timeout

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_ctl_reg u_uart_ctl_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data),
    .tx_enable(tx_enable), .rx_enable(rx_enable),
    .tx_rst_req(tx_rst_req), .rx_rst_req(rx_rst_req),
    .rto_restart_req(rto_restart_req),
    .tx_rst_done(dn[1]), .rx_rst_done(dn[0]), .rto_done(dn[2]),
    .tx_flush(tx_flush), .rx_flush(rx_flush),
    .brk_go(brk_go), .brk_halt(brk_halt)
  );

  logic [2:0] reqs;
  logic [1:0] flushes;
  assign reqs    = {rto_restart_req, tx_rst_req, rx_rst_req};
  assign flushes = {tx_flush, rx_flush};

  // {write, expected read, tx_en, rx_en, go, halt}
  localparam logic [67:0] VEC [9] = '{
    {32'h0000_0014, 32'h0000_0014, 1'b1, 1'b1, 1'b0, 1'b0},
    {32'h0000_003C, 32'h0000_003C, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'h0000_001C, 32'h0000_001C, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'h0000_0034, 32'h0000_0034, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_0080, 32'h0000_0080, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_0180, 32'h0000_0100, 1'b0, 1'b0, 1'b0, 1'b1},
    {32'hFFFF_FE00, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'hFFFF_FFBC, 32'h0000_013C, 1'b0, 1'b0, 1'b0, 1'b1},
    {32'h0000_0094, 32'h0000_0094, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_read(output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic pulse_done(input int idx);
    @(negedge clk); dn[idx] = 1'b1;
    @(negedge clk); dn[idx] = 1'b0;
  endtask

  task automatic run_cmd(input int idx, input logic [31:0] bitv, input string rq);
    logic [31:0] v;
    logic [1:0]  fexp;
    fexp = (idx == 0) ? 2'b01 : (idx == 1) ? 2'b10 : 2'b00;
    do_write(bitv);
    chk({rq, " request raised"}, 32'(reqs[idx]), 32'd1);
    chk("R9 flush on start", 32'(flushes), 32'(fexp));
    @(negedge clk);
    chk("R9 flush one cycle", 32'(flushes), 32'd0);
    do_read(v);
    chk({rq, " bit reads 1 while pending"}, v & bitv, bitv);
    do_write(32'h0);
    chk("R8 write 0 keeps request", 32'(reqs[idx]), 32'd1);
    do_write(bitv);
    chk("R8 rewrite gives no flush", 32'(flushes), 32'd0);
    pulse_done(idx);
    chk({rq, " cleared after done"}, 32'(reqs[idx]), 32'd0);
    do_read(v);
    chk({rq, " bit reads 0 after done"}, v & bitv, 32'd0);
    pulse_done(idx);
    chk("R8 done while idle ignored", 32'(reqs), 32'd0);
    // start again, then done and a fresh write of 1 in one cycle
    do_write(bitv);
    @(negedge clk); wr_en = 1'b1; wr_data = bitv; dn[idx] = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_data = '0; dn[idx] = 1'b0;
    chk("R8 done with same-cycle write clears", 32'(reqs[idx]), 32'd0);
    chk("R8 same-cycle write no flush", 32'(flushes), 32'd0);
    @(negedge clk);
    chk("R8 same-cycle write no restart", 32'(reqs), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    do_read(v);
    chk("R1 reset read", v, 32'h0000_0128);
    chk("R1 reset outputs",
        {23'd0, tx_enable, rx_enable, reqs, flushes, brk_go, brk_halt}, 32'h1);

    // table walk: R2 R3 R4 R10
    foreach (VEC[i]) begin
      do_write(VEC[i][67:36]);
      chk("R3 tx_enable", 32'(tx_enable), 32'(VEC[i][3]));
      chk("R4 rx_enable", 32'(rx_enable), 32'(VEC[i][2]));
      chk("R10 break outputs", {30'd0, brk_go, brk_halt}, {30'd0, VEC[i][1:0]});
      chk("R2 no command from reserved", 32'(reqs), 32'd0);
      do_read(v);
      chk("R2 R10 read back", v, VEC[i][35:4]);
    end

    // R11 read and write in one cycle return the old word
    do_write(32'h0000_0014);
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; wr_data = 32'h0000_0128;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R11 read before same-cycle write", rd_data, 32'h0000_0014);
    repeat (2) @(negedge clk);
    chk("R11 read data holds", rd_data, 32'h0000_0014);
    do_read(v);
    chk("R11 later read sees write", v, 32'h0000_0128);

    run_cmd(1, 32'h0000_0002, "R5");
    run_cmd(0, 32'h0000_0001, "R6");
    run_cmd(2, 32'h0000_0040, "R7");

    // R1 reset while a command is pending
    do_write(32'h0000_0043);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset clears requests", 32'(reqs), 32'd0);
    do_read(v);
    chk("R1 reset read after command", v, 32'h0000_0128);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule